// File: doc/BRIEF.md
# Coprocessor Program Fetch Sequencer

This block walks a small fixed-function coprocessor through its program once in every input multiplexer cycle. When the cycle-start strobe arrives, it samples a 5-bit location value, computes the program base as that value times 1024 bytes, and fetches 16-bit instruction words from a byte-wide shared flash. Each word is built from two byte reads, low byte first, and handed out with a one-cycle valid strobe and its word index. The pass ends when the HALT opcode is decoded. After that nothing more is fetched until the next cycle start.

The flash port is shared with a host processor. While a pass is running, the sequencer has priority. The host is granted the port only in cycles where the sequencer issues no read: while it is idle, and in the decode slot that follows each word's two byte reads. A pass that is still running when the cycle-end strobe arrives, or that reaches the last program word without a HALT, sets a sticky overrun flag that stays set until reset.

Top module: `cp_fetch_seq`

## Requirements
- R1: After synchronous reset, busy, overrun and instr_valid are 0.
- R2: A cycle-start strobe sampled at a clock edge starts a pass at word 0. In the next cycle the flash read address is 1024 times the sampled location value.
- R3: Word n of a pass is read as the low byte at base+2n and then the high byte at base+2n+1. Each word takes three cycles. It appears as instr_word = {high, low} with instr_idx = n and instr_valid high for exactly one cycle.
- R4: A word equal to the HALT opcode 16'hC0DE is presented and ends the pass. busy then drops and no further flash reads are issued by the sequencer.
- R5: A cycle-start strobe during a running pass restarts it at word 0.
- R6: A cycle-end strobe while busy sets overrun, which stays set until reset. A cycle-end strobe while idle leaves overrun at 0.
- R7: If word 1023 is not HALT, the pass stops after presenting it and overrun is set.
- R8: host_gnt is asserted exactly when host_req is high and the sequencer issues no read that cycle. While it is asserted, the flash address is host_addr and the flash read enable is high.
- R9: Changes of loc_reg during a pass do not affect the addresses of that pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | Multiplexer state 0 begins (one-cycle strobe) |
| cyc_end | input | 1 | Multiplexer cycle ends (one-cycle strobe) |
| loc_reg | input | 5 | Program location in 1 KB units |
| flash_rd | output | 1 | Flash byte read enable |
| flash_addr | output | 16 | Flash byte address |
| flash_rdata | input | 8 | Flash read data, valid the cycle after the read |
| host_req | input | 1 | Host requests the flash port |
| host_addr | input | 16 | Host byte address |
| host_gnt | output | 1 | Host owns the flash port this cycle |
| instr_valid | output | 1 | Decoded word strobe |
| instr_word | output | 16 | Assembled instruction word |
| instr_idx | output | 10 | Word index within the pass |
| busy | output | 1 | Pass in progress |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench sweeps all 32 location values and compares every presented word against an address-coded flash pattern. A base that is shifted or truncated, or byte halves that are swapped, would show up as a wrong word value. It restarts a pass in mid-flight and expects the index to fall back to 0. It runs a program with no HALT to the 1023 limit, where a design that wraps the counter or misses the flag would run on or leave overrun clear. It keeps the host requesting through a whole pass and expects exactly one grant per word. A design that lets the host in during a fetch, or starves it, would change that count or corrupt the words.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int LOC_W      = 5;
    localparam int ADDR_W     = 16;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = 2 * BYTE_W;
    localparam int PROG_WORDS = 1024;
    localparam int PC_W       = $clog2(PROG_WORDS);
    localparam int KB_SHIFT   = 10;
    localparam logic [WORD_W-1:0] HALT_OP = 16'hC0DE;
    localparam logic [PC_W-1:0]   LAST_PC = PC_W'(PROG_WORDS - 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2,
        ST_DEC  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
    } flash_req_t;

    function automatic logic [ADDR_W-1:0] prog_base(input logic [LOC_W-1:0] loc);
        return ADDR_W'(loc) << KB_SHIFT;
    endfunction

    function automatic logic [ADDR_W-1:0] byte_addr(input logic [ADDR_W-1:0] base,
                                                    input logic [PC_W-1:0]   pc,
                                                    input logic              hi);
        return base + ADDR_W'({pc, hi});
    endfunction

endpackage

// File: rtl/seq_flash_arb.sv
module seq_flash_arb
    import seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  flash_req_t        seq_req,
    input  logic              host_req,
    input  logic [ADDR_W-1:0] host_addr,
    output logic              flash_rd,
    output logic [ADDR_W-1:0] flash_addr,
    output logic              host_gnt
);

    always_comb begin
        host_gnt   = host_req && !seq_req.rd;
        flash_rd   = seq_req.rd || host_gnt;
        flash_addr = seq_req.rd ? seq_req.addr : host_addr;
    end

    // R8
    no_dual_use_chk: assert property (@(posedge clk) disable iff (rst)
        host_gnt |-> (!seq_req.rd && flash_addr == host_addr));

    // R8
    host_served_chk: assert property (@(posedge clk) disable iff (rst)
        (host_req && !seq_req.rd) |-> host_gnt);

endmodule

// File: rtl/seq_word_asm.sv
module seq_word_asm
    import seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_lo,
    input  logic              cap_hi,
    input  logic [BYTE_W-1:0] rdata,
    input  logic [PC_W-1:0]   pc,
    output logic [WORD_W-1:0] word_now,
    output logic              instr_valid,
    output logic [WORD_W-1:0] instr_word,
    output logic [PC_W-1:0]   instr_idx
);

    logic [BYTE_W-1:0] lo_q;

    assign word_now = {rdata, lo_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q        <= '0;
            instr_valid <= 1'b0;
            instr_word  <= '0;
            instr_idx   <= '0;
        end else begin
            if (cap_lo) begin
                lo_q <= rdata;
            end
            instr_valid <= cap_hi;
            if (cap_hi) begin
                instr_word <= word_now;
                instr_idx  <= pc;
            end
        end
    end

    // R3
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        instr_valid |=> !instr_valid);

    // R3
    lo_before_hi_chk: assert property (@(posedge clk) disable iff (rst)
        cap_lo |=> cap_hi);

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_start,
    input  logic              cyc_end,
    input  logic [LOC_W-1:0]  loc_reg,
    input  logic [WORD_W-1:0] word_now,
    output flash_req_t        fetch,
    output logic              cap_lo,
    output logic              cap_hi,
    output logic [PC_W-1:0]   pc,
    output logic              busy,
    output logic              overrun
);

    seq_state_e        state_q;
    logic [PC_W-1:0]   pc_q;
    logic [ADDR_W-1:0] base_q;
    logic              ovr_q;
    logic              is_halt;

    assign is_halt = (word_now == HALT_OP);

    always_comb begin
        fetch.rd   = (state_q == ST_LO) || (state_q == ST_HI);
        fetch.addr = byte_addr(base_q, pc_q, state_q == ST_HI);
        cap_lo     = (state_q == ST_HI);
        cap_hi     = (state_q == ST_DEC);
        pc         = pc_q;
        busy       = (state_q != ST_IDLE);
        overrun    = ovr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
            base_q  <= '0;
            ovr_q   <= 1'b0;
        end else begin
            if (cyc_end && state_q != ST_IDLE) begin
                ovr_q <= 1'b1;
            end
            if (cyc_start) begin
                state_q <= ST_LO;
                pc_q    <= '0;
                base_q  <= prog_base(loc_reg);
            end else begin
                unique case (state_q)
                    ST_IDLE: state_q <= ST_IDLE;
                    ST_LO:   state_q <= ST_HI;
                    ST_HI:   state_q <= ST_DEC;
                    ST_DEC: begin
                        if (is_halt) begin
                            state_q <= ST_IDLE;
                        end else if (pc_q == LAST_PC) begin
                            state_q <= ST_IDLE;
                            ovr_q   <= 1'b1;
                        end else begin
                            pc_q    <= pc_q + 1'b1;
                            state_q <= ST_LO;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // R2
    start_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_start |=> (state_q == ST_LO && pc_q == '0));

    // R4
    halt_stops_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DEC && is_halt && !cyc_start) |=> (state_q == ST_IDLE));

    // R4
    idle_no_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> !fetch.rd);

    // R6
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovr_q |=> ovr_q);

    // R6
    end_busy_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_end && state_q != ST_IDLE) |=> ovr_q);

    // R7
    last_word_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DEC && pc_q == LAST_PC && !is_halt && !cyc_start)
            |=> (ovr_q && state_q == ST_IDLE));

    // R9
    base_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && !cyc_start) |=> $stable(base_q));

endmodule

// File: rtl/cp_fetch_seq.sv
module cp_fetch_seq
    import seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_start,
    input  logic              cyc_end,
    input  logic [LOC_W-1:0]  loc_reg,
    output logic              flash_rd,
    output logic [ADDR_W-1:0] flash_addr,
    input  logic [BYTE_W-1:0] flash_rdata,
    input  logic              host_req,
    input  logic [ADDR_W-1:0] host_addr,
    output logic              host_gnt,
    output logic              instr_valid,
    output logic [WORD_W-1:0] instr_word,
    output logic [PC_W-1:0]   instr_idx,
    output logic              busy,
    output logic              overrun
);

    flash_req_t        fetch;
    logic              cap_lo;
    logic              cap_hi;
    logic [PC_W-1:0]   pc;
    logic [WORD_W-1:0] word_now;

    seq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cyc_start (cyc_start),
        .cyc_end   (cyc_end),
        .loc_reg   (loc_reg),
        .word_now  (word_now),
        .fetch     (fetch),
        .cap_lo    (cap_lo),
        .cap_hi    (cap_hi),
        .pc        (pc),
        .busy      (busy),
        .overrun   (overrun)
    );

    seq_word_asm u_asm (
        .clk         (clk),
        .rst         (rst),
        .cap_lo      (cap_lo),
        .cap_hi      (cap_hi),
        .rdata       (flash_rdata),
        .pc          (pc),
        .word_now    (word_now),
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .instr_idx   (instr_idx)
    );

    seq_flash_arb u_arb (
        .clk        (clk),
        .rst        (rst),
        .seq_req    (fetch),
        .host_req   (host_req),
        .host_addr  (host_addr),
        .flash_rd   (flash_rd),
        .flash_addr (flash_addr),
        .host_gnt   (host_gnt)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !overrun && !instr_valid));

endmodule

// File: tb/cp_fetch_seq_bench.sv
`timescale 1ns/100ps
module cp_fetch_seq_bench;

    localparam logic [15:0] HALT = 16'hC0DE;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc_start = 1'b0;
    logic        cyc_end = 1'b0;
    logic [4:0]  loc_reg = '0;
    logic        flash_rd;
    logic [15:0] flash_addr;
    logic [7:0]  flash_rdata = '0;
    logic        host_req = 1'b0;
    logic [15:0] host_addr = 16'h1234;
    logic        host_gnt;
    logic        instr_valid;
    logic [15:0] instr_word;
    logic [9:0]  instr_idx;
    logic        busy;
    logic        overrun;

    int errors = 0;
    int checks = 0;
    int cur_base = 0;
    int halt_idx = 0;
    int exp_idx = 0;
    int mon_cnt = 0;
    int last_idx = -1;
    int gnt_busy = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    cp_fetch_seq u_cp_fetch_seq (
        .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_end(cyc_end),
        .loc_reg(loc_reg), .flash_rd(flash_rd), .flash_addr(flash_addr),
        .flash_rdata(flash_rdata), .host_req(host_req), .host_addr(host_addr),
        .host_gnt(host_gnt), .instr_valid(instr_valid), .instr_word(instr_word),
        .instr_idx(instr_idx), .busy(busy), .overrun(overrun)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_at(input logic [15:0] a);
        int wi;
        wi = int'(a[15:1]);
        if (wi == cur_base / 2 + halt_idx)
            return a[0] ? HALT[15:8] : HALT[7:0];
        return a[0] ? {1'b0, a[15:9]} : a[8:1];
    endfunction

    function automatic logic [15:0] exp_word(input int idx);
        if (idx == halt_idx) return HALT;
        return 16'(cur_base / 2 + idx);
    endfunction

    // flash model: one-cycle read latency
    always @(posedge clk) begin
        if (flash_rd) flash_rdata <= byte_at(flash_addr);
    end

    // output monitor, sampled 1 ns after the edge
    always @(posedge clk) begin
        #1;
        cycles++;
        if (!rst && busy && host_gnt) gnt_busy++;
        if (!rst && host_gnt)
            check(flash_addr == host_addr && flash_rd, "R8 host owns port", flash_addr, host_addr);
        if (!rst && instr_valid) begin
            check(int'(instr_idx) == exp_idx, "R3 word index", instr_idx, exp_idx);
            check(instr_word == exp_word(int'(instr_idx)), "R3 word value", instr_word,
                  exp_word(int'(instr_idx)));
            exp_idx = int'(instr_idx) + 1;
            last_idx = int'(instr_idx);
            mon_cnt++;
        end
    end

    // watchdog
    initial begin
        #(5ns * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cyc_start = 0; cyc_end = 0; host_req = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(!busy && !overrun && !instr_valid, "R1 reset state",
              {busy, overrun, instr_valid}, 0);
    endtask

    task automatic arm(input int loc, input int hidx);
        loc_reg = 5'(loc);
        cur_base = loc * 1024;
        halt_idx = hidx;
        exp_idx = 0;
        mon_cnt = 0;
        last_idx = -1;
    endtask

    task automatic pulse_start();
        @(negedge clk) cyc_start = 1'b1;
        @(negedge clk) cyc_start = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 4000) begin
            @(negedge clk);
            n++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic run_pass(input int loc, input int hidx, input string tag);
        arm(loc, hidx);
        pulse_start();
        check(flash_rd && flash_addr == 16'(loc * 1024), {tag, " R2 first address"},
              flash_addr, loc * 1024);
        wait_idle();
        check(mon_cnt == hidx + 1, {tag, " R4 words in pass"}, mon_cnt, hidx + 1);
        check(!busy && !flash_rd, {tag, " R4 idle after HALT"}, {busy, flash_rd}, 0);
    endtask

    task automatic test_lengths();
        do_reset();
        run_pass(2, 0, "len1");
        run_pass(5, 7, "len8");
        run_pass(17, 63, "len64");
        check(!overrun, "R6 no overrun on clean passes", overrun, 0);
    endtask

    task automatic test_all_locations();
        do_reset();
        for (int l = 0; l < 32; l++) run_pass(l, 1, "loc");
    endtask

    task automatic test_restart();
        do_reset();
        arm(4, 40);
        pulse_start();
        repeat (18) @(negedge clk);
        cyc_start = 1'b1;
        exp_idx = 0;
        mon_cnt = 0;
        @(negedge clk) cyc_start = 1'b0;
        check(busy && flash_addr == 16'(4 * 1024), "R5 restart at word 0", flash_addr, 4 * 1024);
        wait_idle();
        check(mon_cnt == 41, "R5 full pass after restart", mon_cnt, 41);
    endtask

    task automatic test_loc_change();
        do_reset();
        arm(3, 12);
        pulse_start();
        loc_reg = 5'd9;
        wait_idle();
        check(mon_cnt == 13 && last_idx == 12, "R9 location held during pass", last_idx, 12);
    endtask

    task automatic test_cycle_end();
        do_reset();
        @(negedge clk) cyc_end = 1'b1;
        @(negedge clk) cyc_end = 1'b0;
        check(!overrun, "R6 cycle end while idle", overrun, 0);
        arm(6, 20);
        pulse_start();
        repeat (10) @(negedge clk);
        cyc_end = 1'b1;
        @(negedge clk) cyc_end = 1'b0;
        check(overrun, "R6 cycle end while busy", overrun, 1);
        wait_idle();
        repeat (5) @(negedge clk);
        check(overrun, "R6 overrun sticky", overrun, 1);
        check(mon_cnt == 21, "R6 pass continues to HALT", mon_cnt, 21);
    endtask

    task automatic test_limit();
        do_reset();
        arm(30, 5000);
        pulse_start();
        wait_idle();
        check(mon_cnt == 1024, "R7 words before limit", mon_cnt, 1024);
        check(last_idx == 1023, "R7 last index", last_idx, 1023);
        check(overrun && !busy, "R7 overrun at limit", {overrun, busy}, 2);
    endtask

    task automatic test_host();
        do_reset();
        @(negedge clk);
        host_req = 1'b1;
        host_addr = 16'h7A51;
        #0.5;
        check(host_gnt && flash_rd && flash_addr == 16'h7A51, "R8 idle grant",
              flash_addr, 16'h7A51);
        arm(11, 30);
        gnt_busy = 0;
        pulse_start();
        wait_idle();
        check(gnt_busy == 31, "R8 one host slot per word", gnt_busy, 31);
        check(mon_cnt == 31, "R8 words intact with host active", mon_cnt, 31);
        host_req = 1'b0;
    endtask

    initial begin
        test_lengths();
        test_all_locations();
        test_restart();
        test_loc_change();
        test_cycle_end();
        test_limit();
        test_host();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule